// File: doc/BRIEF.md
# GPIO Pin Interrupt Controller

This block watches a port of general-purpose input pins and turns selected pin activity into a single interrupt request for a parent interrupt controller. Every pin first passes through a two-stage synchronizer. Each pin is then classified by two configuration bits. The kind bit selects level or edge detection, and the sense bit selects the active direction. Edge events are latched as sticky flags. Level conditions are reported live. An enable bit and a separate mask bit per pin decide whether that pin's flag reaches the shared request line.

Software reaches the block through a small word-addressed register port with a one-cycle read response. The hardware has no mode that catches both edges of a pin. Software emulates it: after each event it reads the synchronized pin levels and writes each affected sense bit to the inverse of the pin's present level. Because writes carry a per-bit write mask, one pin's configuration changes without disturbing the others. Reading the flag register hands the latched edge flags to software and clears them in the same access.

The bus side is a two-state machine. In state BUS_IDLE the port is ready and accepts a request. The transition "read accepted" moves it to BUS_RESP; a write leaves it in BUS_IDLE. BUS_RESP presents the read word for one cycle and takes the unconditional transition "response delivered" back to BUS_IDLE.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: After reset, every configuration register and every flag reads as zero, `irq_out` is low and `req_ready` is high. All pins start as edge kind, falling sense, disabled and unmasked.
- R2: The input-level register returns each pin's value after the two-flop synchronizer. A pin value held for three clock cycles is read back exactly.
- R3: A write updates only the bits of the addressed register where `req_wbits` is 1. Bits where `req_wbits` is 0 keep their value. Writes to the input-level and flag registers change nothing.
- R4: For an edge-kind pin (kind bit 0), the flag is set by a rising edge of the synchronized pin when its sense bit is 1, and by a falling edge when its sense bit is 0. The opposite edge sets nothing.
- R5: Edge flags are sticky across further edges until the flag register is read. That read returns them and clears them. An edge detected in the same cycle as that read leaves the flag set.
- R6: For a level-kind pin (kind bit 1), the flag is 1 exactly while the synchronized pin equals its sense bit. The flag is not latched, and reading it does not clear it.
- R7: Changing a sense bit while the pin is steady never sets a flag. After each event, writing the sense bit to the inverse of the pin level catches the next edge in either direction.
- R8: `irq_out` is a registered OR over all pins of (flag AND enable AND NOT mask). It is high only when some flagged pin is both enabled and unmasked.
- R9: `req_ready` is high only in BUS_IDLE. An accepted read gives `rd_valid` high for exactly the next cycle, with `rd_data` holding the addressed word. Unmapped or misaligned addresses read zero.
- R10: Byte offsets are: input level 0x00, kind 0x04, sense 0x08, enable 0x0C, mask 0x10, flags 0x14. Bit n of each register belongs to pin n. Kind 1 means level and 0 means edge. Sense 1 means rising or high, and 0 means falling or low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | NPINS | Raw asynchronous pin levels |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Port can accept a request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 5 | Byte address of the register |
| req_wdata | input | NPINS | Write data |
| req_wbits | input | NPINS | Per-bit write mask, 1 = update |
| rd_valid | output | 1 | Read word is valid this cycle |
| rd_data | output | NPINS | Read word |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench builds the controller with NPINS = 8. This small width lets it sweep all 256 pin patterns through the synchronizer and the input-level register. It also runs long pseudo-random pin sequences under four kind and sense mixes. Each mix has edge and level pins side by side, and every flag is predicted by arithmetic on the previous and new pin words. Directed sequences cover the case where an edge meets a flag read in the same cycle, the emulation of catching both edges by flipping the sense bit, and all four enable/mask combinations on the request line.

// File: rtl/gpio_irq_pkg.sv
`timescale 1ns/1ps
package gpio_irq_pkg;

    localparam int ADDR_W = 5;
    localparam int IDX_W  = ADDR_W - 2;
    localparam int SYNC_STAGES = 2;

    typedef enum logic [IDX_W-1:0] {
        SEL_LEVEL  = 3'd0,
        SEL_KIND   = 3'd1,
        SEL_SENSE  = 3'd2,
        SEL_ENABLE = 3'd3,
        SEL_MASK   = 3'd4,
        SEL_FLAGS  = 3'd5
    } reg_sel_e;

    localparam int NUM_CFG = 4;
    localparam logic [ADDR_W-1:0] ADDR_FLAGS = 5'h14;

    typedef enum logic {
        BUS_IDLE = 1'b0,
        BUS_RESP = 1'b1
    } bus_state_e;

endpackage

// File: rtl/gpio_irq_sync.sv
`timescale 1ns/1ps
module gpio_irq_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] raw_in,
    output logic [NPINS-1:0] sync_out
);

    logic [NPINS-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        logic [NPINS-1:0] feed;
        if (s == 0) begin : g_first
            assign feed = raw_in;
        end else begin : g_next
            assign feed = stage_q[s-1];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q[s] <= '0;
            end else begin
                stage_q[s] <= feed;
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_irq_detect.sv
`timescale 1ns/1ps
module gpio_irq_detect #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] level_in,
    input  logic [NPINS-1:0] kind_in,
    input  logic [NPINS-1:0] sense_in,
    input  logic [NPINS-1:0] clear_in,
    output logic [NPINS-1:0] flag_out
);

    logic [NPINS-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= level_in;
        end
    end

    for (genvar p = 0; p < NPINS; p++) begin : g_pin
        logic rise;
        logic fall;
        logic hit;
        logic active_lvl;
        logic latch_q;
        logic latch_d;

        always_comb begin
            rise       = level_in[p] & ~prev_q[p];
            fall       = ~level_in[p] & prev_q[p];
            hit        = sense_in[p] ? rise : fall;
            active_lvl = ~(level_in[p] ^ sense_in[p]);
            if (kind_in[p]) begin
                latch_d = 1'b0;
            end else begin
                latch_d = (latch_q & ~clear_in[p]) | hit;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                latch_q <= 1'b0;
            end else begin
                latch_q <= latch_d;
            end
        end

        assign flag_out[p] = kind_in[p] ? active_lvl : latch_q;
    end

endmodule

// File: rtl/gpio_irq_regs.sv
`timescale 1ns/1ps
module gpio_irq_regs
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NPINS-1:0]  req_wdata,
    input  logic [NPINS-1:0]  req_wbits,
    input  logic [NPINS-1:0]  level_in,
    input  logic [NPINS-1:0]  flag_in,
    output logic [NPINS-1:0]  kind_q,
    output logic [NPINS-1:0]  sense_q,
    output logic [NPINS-1:0]  enable_q,
    output logic [NPINS-1:0]  mask_q,
    output logic [NPINS-1:0]  clear_out,
    output logic              req_ready,
    output logic              rd_valid,
    output logic [NPINS-1:0]  rd_data
);

    bus_state_e       state_q;
    bus_state_e       state_d;
    logic [IDX_W-1:0] idx;
    logic             aligned;
    logic             mapped;
    reg_sel_e         sel;
    logic             accept;
    logic             wr_en;
    logic             rd_en;
    logic [NPINS-1:0] rd_mux;
    logic [NPINS-1:0] rd_data_q;
    logic [NPINS-1:0] cfg_q [NUM_CFG];

    assign idx     = req_addr[ADDR_W-1:2];
    assign aligned = (req_addr[1:0] == 2'b00);
    assign mapped  = aligned && (idx <= IDX_W'(SEL_FLAGS));
    assign sel     = reg_sel_e'(idx);
    assign accept  = req_valid && (state_q == BUS_IDLE);
    assign wr_en   = accept && req_write && mapped;
    assign rd_en   = accept && !req_write;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (rd_en) begin
                    state_d = BUS_RESP;
                end
            end
            BUS_RESP: begin
                state_d = BUS_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // state outputs
    always_comb begin
        req_ready = 1'b0;
        rd_valid  = 1'b0;
        unique case (state_q)
            BUS_IDLE: req_ready = 1'b1;
            BUS_RESP: rd_valid  = 1'b1;
        endcase
    end

    // configuration registers, one per selector after the level register
    for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
        localparam reg_sel_e GSEL = reg_sel_e'(IDX_W'(g + 1));
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                cfg_q[g] <= '0;
            end else if (wr_en && (sel == GSEL)) begin
                cfg_q[g] <= (cfg_q[g] & ~req_wbits) | (req_wdata & req_wbits);
            end
        end
    end

    assign kind_q   = cfg_q[0];
    assign sense_q  = cfg_q[1];
    assign enable_q = cfg_q[2];
    assign mask_q   = cfg_q[3];

    always_comb begin
        rd_mux = '0;
        if (mapped) begin
            case (sel)
                SEL_LEVEL:  rd_mux = level_in;
                SEL_KIND:   rd_mux = kind_q;
                SEL_SENSE:  rd_mux = sense_q;
                SEL_ENABLE: rd_mux = enable_q;
                SEL_MASK:   rd_mux = mask_q;
                SEL_FLAGS:  rd_mux = flag_in;
                default:    rd_mux = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd_en) begin
            rd_data_q <= rd_mux;
        end
    end

    assign rd_data   = rd_data_q;
    assign clear_out = (rd_en && mapped && (sel == SEL_FLAGS)) ? flag_in : '0;

endmodule

// File: rtl/gpio_irq_ctrl.sv
`timescale 1ns/1ps
module gpio_irq_ctrl
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NPINS-1:0]  pin_in,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [NPINS-1:0]  req_wdata,
    input  logic [NPINS-1:0]  req_wbits,
    output logic              rd_valid,
    output logic [NPINS-1:0]  rd_data,
    output logic              irq_out
);

    logic [NPINS-1:0] sync_lvl;
    logic [NPINS-1:0] kind_q;
    logic [NPINS-1:0] sense_q;
    logic [NPINS-1:0] en_q;
    logic [NPINS-1:0] mask_q;
    logic [NPINS-1:0] clear_vec;
    logic [NPINS-1:0] flag_vec;
    logic             irq_q;

    gpio_irq_sync #(
        .NPINS  (NPINS),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .raw_in   (pin_in),
        .sync_out (sync_lvl)
    );

    gpio_irq_detect #(
        .NPINS (NPINS)
    ) u_detect (
        .clk      (clk),
        .rst_n    (rst_n),
        .level_in (sync_lvl),
        .kind_in  (kind_q),
        .sense_in (sense_q),
        .clear_in (clear_vec),
        .flag_out (flag_vec)
    );

    gpio_irq_regs #(
        .NPINS (NPINS)
    ) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_wbits (req_wbits),
        .level_in  (sync_lvl),
        .flag_in   (flag_vec),
        .kind_q    (kind_q),
        .sense_q   (sense_q),
        .enable_q  (en_q),
        .mask_q    (mask_q),
        .clear_out (clear_vec),
        .req_ready (req_ready),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= |(flag_vec & en_q & ~mask_q);
        end
    end

    assign irq_out = irq_q;

endmodule

// File: rtl/gpio_irq_ctrl_chk.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_chk
    import gpio_irq_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic              rd_valid,
    input logic              irq_out,
    input logic [NPINS-1:0]  en_q,
    input logic [NPINS-1:0]  mask_q,
    input logic [NPINS-1:0]  kind_q,
    input logic [NPINS-1:0]  flag_vec
);

    logic flag_read;
    assign flag_read = req_valid && req_ready && !req_write && (req_addr == ADDR_FLAGS);

    // R9: no new request is taken while a response is shown
    p_ready_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !req_ready);

    // R9: the response lasts a single cycle
    p_resp_once_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);

    // R9: an accepted read is answered on the next cycle
    p_read_answer_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_write) |=> rd_valid);

    // R8: the request only rises if some pin was enabled and unmasked
    p_irq_gate_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(|(en_q & ~mask_q)));

    // R5: an edge flag on pin 0 stays until a flag read
    p_edge_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!kind_q[0] && $past(!kind_q[0]) && $past(flag_vec[0]) && !$past(flag_read))
            |-> flag_vec[0]);

endmodule

bind gpio_irq_ctrl gpio_irq_ctrl_chk #(.NPINS(NPINS)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rd_valid  (rd_valid),
    .irq_out   (irq_out),
    .en_q      (en_q),
    .mask_q    (mask_q),
    .kind_q    (kind_q),
    .flag_vec  (flag_vec)
);

// File: tb/gpio_irq_ctrl_bench.sv
`timescale 1ns/1ps
module gpio_irq_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam logic [4:0] A_LEVEL = 5'h00;
    localparam logic [4:0] A_KIND  = 5'h04;
    localparam logic [4:0] A_SENSE = 5'h08;
    localparam logic [4:0] A_EN    = 5'h0C;
    localparam logic [4:0] A_MASK  = 5'h10;
    localparam logic [4:0] A_FLAGS = 5'h14;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] pin_in = '0;
    logic          req_valid = 1'b0;
    logic          req_ready;
    logic          req_write = 1'b0;
    logic [4:0]    req_addr = '0;
    logic [NP-1:0] req_wdata = '0;
    logic [NP-1:0] req_wbits = '0;
    logic          rd_valid;
    logic [NP-1:0] rd_data;
    logic          irq_out;

    int vectors = 0;
    int miscompares = 0;
    logic done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_irq_ctrl #(.NPINS(NP)) u_gpio_irq_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .pin_in    (pin_in),
        .req_valid (req_valid),
        .req_ready (req_ready),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .req_wbits (req_wbits),
        .rd_valid  (rd_valid),
        .rd_data   (rd_data),
        .irq_out   (irq_out)
    );

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic bus_write(input logic [4:0] a, input logic [NP-1:0] d, input logic [NP-1:0] b);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_wbits = b;
        @(posedge clk);
        #1 req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_read(input logic [4:0] a, output logic [NP-1:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        #1 req_valid = 1'b0;
        @(negedge clk);
        chk(32'(rd_valid), 32'd1, "R9 rd_valid after read");
        chk(32'(req_ready), 32'd0, "R9 ready low in response");
        d = rd_data;
    endtask

    task automatic set_pins(input logic [NP-1:0] v);
        @(negedge clk);
        pin_in = v;
        repeat (3) @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R9 watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

    initial begin
        logic [NP-1:0] rd;
        logic [NP-1:0] m_cfg [4];
        logic [NP-1:0] ty, po, old, nv, hit, exp_edge;

        // R1: reset state
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(32'(irq_out), 0, "R1 irq after reset");
        chk(32'(req_ready), 1, "R1 ready after reset");
        for (int r = 0; r < 6; r++) begin
            bus_read(5'(r * 4), rd);
            chk(32'(rd), 0, "R1 R10 register zero after reset");
        end

        // R2: every pin pattern through the synchronizer
        for (int v = 0; v < 256; v++) begin
            set_pins(NP'(v));
            bus_read(A_LEVEL, rd);
            chk(32'(rd), 32'(v), "R2 input level");
        end
        bus_read(A_FLAGS, rd);

        // R3: masked writes to configuration registers
        for (int k = 0; k < 4; k++) m_cfg[k] = '0;
        for (int i = 0; i < 20; i++) begin
            logic [NP-1:0] val, bits;
            int t;
            val  = NP'(i * 73 + 5);
            bits = NP'(i * 29 + 3);
            t    = i % 4;
            bus_write(5'((t + 1) * 4), val, bits);
            m_cfg[t] = (m_cfg[t] & ~bits) | (val & bits);
            bus_read(5'((t + 1) * 4), rd);
            chk(32'(rd), 32'(m_cfg[t]), "R3 R10 masked write");
        end
        for (int k = 0; k < 4; k++) bus_write(5'((k + 1) * 4), '0, '1);
        set_pins(8'h3C);
        bus_read(A_FLAGS, rd);
        bus_write(A_LEVEL, 8'hFF, 8'hFF);
        bus_write(A_FLAGS, 8'hFF, 8'hFF);
        bus_read(A_LEVEL, rd);
        chk(32'(rd), 32'h3C, "R3 write to input level ignored");
        bus_read(A_FLAGS, rd);
        chk(32'(rd), 0, "R3 write to flags ignored");

        // R4 R5 R6: mixed edge and level pins under pseudo-random pin sequences
        for (int c = 0; c < 4; c++) begin
            ty = NP'(c * 8'h35);
            po = NP'(c * 8'h5C + 8'h33);
            bus_write(A_KIND, ty, 8'hFF);
            bus_write(A_SENSE, po, 8'hFF);
            repeat (3) @(posedge clk);
            bus_read(A_FLAGS, rd);
            exp_edge = '0;
            old = pin_in;
            for (int s = 0; s < 24; s++) begin
                nv  = NP'(s * 8'h3B + c * 8'h11 + 8'h07);
                hit = (po & nv & ~old) | (~po & ~nv & old);
                exp_edge = exp_edge | (hit & ~ty);
                old = nv;
                set_pins(nv);
                if (s % 3 != 2) begin
                    bus_read(A_FLAGS, rd);
                    chk(32'(rd), 32'(exp_edge | (ty & ~(nv ^ po))), "R4 R5 R6 flag word");
                    exp_edge = '0;
                end
            end
        end

        // R5: edge arriving in the same cycle as a flag read
        bus_write(A_KIND, '0, 8'hFF);
        bus_write(A_SENSE, '0, 8'hFF);
        set_pins(8'h01);
        bus_read(A_FLAGS, rd);
        set_pins(8'h00);
        set_pins(8'h01);
        @(negedge clk) pin_in = 8'h00;
        @(posedge clk);
        @(posedge clk);
        bus_read(A_FLAGS, rd);
        chk(32'(rd), 32'h01, "R5 flag returned by coincident read");
        bus_read(A_FLAGS, rd);
        chk(32'(rd), 32'h01, "R5 coincident edge kept");
        bus_read(A_FLAGS, rd);
        chk(32'(rd), 0, "R5 cleared after read");

        // R7: both-edge emulation by rewriting sense
        set_pins(8'h00);
        bus_read(A_FLAGS, rd);
        bus_write(A_SENSE, 8'hFF, 8'hFF);
        repeat (3) @(posedge clk);
        bus_read(A_FLAGS, rd);
        chk(32'(rd), 0, "R7 sense change alone");
        set_pins(8'h02);
        bus_read(A_FLAGS, rd);
        chk(32'(rd), 32'h02, "R7 rising caught");
        bus_write(A_SENSE, ~8'h02, 8'hFF);
        repeat (3) @(posedge clk);
        bus_read(A_FLAGS, rd);
        chk(32'(rd), 0, "R7 sense flip alone");
        set_pins(8'h00);
        bus_read(A_FLAGS, rd);
        chk(32'(rd), 32'h02, "R7 falling caught");

        // R8 R6: level pin 2 through the enable and mask gates
        bus_write(A_KIND, 8'h04, 8'hFF);
        bus_write(A_SENSE, 8'h04, 8'hFF);
        set_pins(8'h04);
        bus_read(A_FLAGS, rd);
        chk(32'(rd), 32'h04, "R6 level flag");
        bus_read(A_FLAGS, rd);
        chk(32'(rd), 32'h04, "R6 level flag not cleared by read");
        for (int g = 0; g < 4; g++) begin
            bus_write(A_EN, (g % 2 == 1) ? 8'h04 : 8'h00, 8'hFF);
            bus_write(A_MASK, (g / 2 == 1) ? 8'h04 : 8'h00, 8'hFF);
            repeat (2) @(posedge clk);
            @(negedge clk);
            chk(32'(irq_out), (g == 1) ? 32'd1 : 32'd0, "R8 irq gating");
        end
        bus_write(A_EN, 8'h04, 8'hFF);
        bus_write(A_MASK, 8'h00, 8'hFF);
        set_pins(8'h00);
        @(negedge clk);
        chk(32'(irq_out), 0, "R6 R8 level released");

        // R9: unmapped and misaligned reads
        bus_read(5'h18, rd);
        chk(32'(rd), 0, "R9 unmapped read");
        bus_read(5'h1C, rd);
        chk(32'(rd), 0, "R9 unmapped read high");
        bus_read(5'h05, rd);
        chk(32'(rd), 0, "R9 misaligned read");

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

endmodule